// File: doc/BRIEF.md
# Hybrid-Rate Third-Order Phase Generator

This block produces a phase word for Doppler signal simulation. It uses three cascaded accumulators. An acceleration stage adds a constant jerk step. A velocity stage adds the acceleration value. A phase stage adds the velocity value. The velocity and phase stages advance on every enabled base-clock cycle. The acceleration stage advances only once every W enabled cycles. Running the top stage slower stretches the jerk profile in time and cuts toggling in the widest adder. With W = 1 the chain is an ordinary same-rate third-order accumulator.

Every stage is a register, so a stage's output lags its input by one cycle. Each stage is wider than the stage below it so that it can hold fractional bits. Before a value feeds the next stage down, its low-order bits are dropped. All stages stay in one clock domain: the slow stage is paced by a clock enable from a modulo-W counter.

A load strobe sets each stage to its programmed initial value, clears the counter, and captures W and the jerk step. Changing these inputs between loads has no effect.

Top module: `dop_phase_gen`

## Requirements
- R1: While rst_ni is low, and after it is released, phase_o is 0 until the first load.
- R2: On a cycle with load_i high, the stages take init_ph_i, init_vel_i and init_acc_i, and phase_o equals init_ph_i on the next cycle. This holds whatever the value of en_i.
- R3: On each cycle with en_i high and load_i low, the phase stage adds the upper PH_W bits of the velocity register, as it was before that edge (velocity shifted right by VEL_W-PH_W).
- R4: On each such cycle, the velocity stage adds the upper VEL_W bits of the acceleration register, as it was before that edge (acceleration shifted right by ACC_W-VEL_W).
- R5: The acceleration stage adds the latched jerk step once every W enabled cycles. The first addition happens on the W-th enabled cycle after a load. On all other cycles the stage holds its value.
- R6: A W input of 0 is treated as 1. With W = 1 the acceleration stage updates on every enabled cycle.
- R7: With en_i low and load_i low, the whole state is held and phase_o does not change.
- R8: Every stage wraps modulo 2 to the power of its width.
- R9: Changes to div_i, jerk_i or any initial value between load strobes have no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Loads initial values, W and jerk; restarts the W counter |
| en_i | input | 1 | Advance enable |
| div_i | input | CNT_W | Division coefficient W for the acceleration stage (0 acts as 1) |
| jerk_i | input | ACC_W | Constant step of the acceleration stage |
| init_acc_i | input | ACC_W | Initial acceleration |
| init_vel_i | input | VEL_W | Initial velocity |
| init_ph_i | input | PH_W | Initial phase |
| phase_o | output | PH_W | Phase word |

## Verification
The hardest state to reach from the ports is the slow stage's timing. The acceleration stage must update exactly on the W-th enabled cycle, and the count must keep going correctly when enable gaps fall inside a W period. Only the phase word is visible, and it shows acceleration only after passing through two truncating stages. The stimulus therefore uses large jerk steps and wide velocity contributions, so that each acceleration update moves the phase within a few cycles. It runs W = 5 with enable toggled in the middle of a period. It also changes W and jerk without a load, and then a reference model checks the phase every cycle.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int unsigned PH_W_DEF  = 32;
  localparam int unsigned VEL_W_DEF = 40;
  localparam int unsigned ACC_W_DEF = 48;
  localparam int unsigned CNT_W_DEF = 16;
endpackage

// File: rtl/dpg_rate_div.sv
module dpg_rate_div #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] div_q, cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_q - CNT_W'(1));
  assign tick_o = en_i && !load_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= CNT_W'(1);
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= (div_i == '0) ? CNT_W'(1) : div_i;
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dpg_accum.sv
module dpg_accum #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  init_i,
  input  logic          upd_i,
  input  logic [SW-1:0] step_i,
  output logic [W-1:0]  acc_o
);
  localparam int unsigned SH = SW - W;

  logic [W-1:0] step_t;
  assign step_t = W'(step_i >> SH);  // drop fractional bits of the upper stage

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (load_i) acc_o <= init_i;
    else if (upd_i)  acc_o <= acc_o + step_t;
  end
endmodule

// File: rtl/dop_phase_gen.sv
module dop_phase_gen
  import dpg_pkg::*;
#(
  parameter int unsigned PH_W  = PH_W_DEF,
  parameter int unsigned VEL_W = VEL_W_DEF,
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] div_i,
  input  logic [ACC_W-1:0] jerk_i,
  input  logic [ACC_W-1:0] init_acc_i,
  input  logic [VEL_W-1:0] init_vel_i,
  input  logic [PH_W-1:0]  init_ph_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] jerk_q, acc_q;
  logic [VEL_W-1:0] vel_q;
  logic [PH_W-1:0]  ph_q;
  logic             acc_tick, run;

  assign run = en_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     jerk_q <= '0;
    else if (load_i) jerk_q <= jerk_i;
  end

  dpg_rate_div #(.CNT_W(CNT_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .en_i(en_i),
    .div_i(div_i), .tick_o(acc_tick)
  );

  dpg_accum #(.W(ACC_W), .SW(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .init_i(init_acc_i),
    .upd_i(acc_tick), .step_i(jerk_q), .acc_o(acc_q)
  );

  dpg_accum #(.W(VEL_W), .SW(ACC_W)) u_vel (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .init_i(init_vel_i),
    .upd_i(run), .step_i(acc_q), .acc_o(vel_q)
  );

  dpg_accum #(.W(PH_W), .SW(VEL_W)) u_ph (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .init_i(init_ph_i),
    .upd_i(run), .step_i(vel_q), .acc_o(ph_q)
  );

  assign phase_o = ph_q;
endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int unsigned PH_W  = 32,
  parameter int unsigned VEL_W = 40,
  parameter int unsigned ACC_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             en_i,
  input logic [PH_W-1:0]  init_ph_i,
  input logic [PH_W-1:0]  phase_o,
  input logic [VEL_W-1:0] vel_q,
  input logic [ACC_W-1:0] acc_q,
  input logic             acc_tick
);
  localparam int unsigned SH_V = VEL_W - PH_W;
  localparam int unsigned SH_A = ACC_W - VEL_W;

  AST_LOAD_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> phase_o == $past(init_ph_i));  // R2
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> phase_o == $past(phase_o) + $past(PH_W'(vel_q >> SH_V)));  // R3
  AST_VEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> vel_q == $past(vel_q) + $past(VEL_W'(acc_q >> SH_A)));  // R4
  AST_ACC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !acc_tick) |=> $stable(acc_q));  // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> ($stable(phase_o) && $stable(vel_q)));  // R7
  AST_NO_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || load_i) |-> !acc_tick);  // R5
endmodule

bind dop_phase_gen dpg_checker #(.PH_W(PH_W), .VEL_W(VEL_W), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .en_i(en_i),
  .init_ph_i(init_ph_i), .phase_o(phase_o), .vel_q(vel_q), .acc_q(acc_q),
  .acc_tick(acc_tick)
);

// File: tb/dop_phase_gen_tb.sv
module dop_phase_gen_tb;
  localparam int PH_W = 32, VEL_W = 40, ACC_W = 48, CNT_W = 16;

  logic clk_i = 0, rst_ni = 0, load_i = 0, en_i = 0;
  logic [CNT_W-1:0] div_i = '0;
  logic [ACC_W-1:0] jerk_i = '0, init_acc_i = '0;
  logic [VEL_W-1:0] init_vel_i = '0;
  logic [PH_W-1:0]  init_ph_i = '0, phase_o;

  int errors = 0, checks = 0;

  // reference model state
  logic [ACC_W-1:0] m_acc = '0, m_jerk = '0;
  logic [VEL_W-1:0] m_vel = '0;
  logic [PH_W-1:0]  m_ph = '0;
  int unsigned m_div = 1, m_cnt = 0;

  always #5 clk_i = ~clk_i;

  dop_phase_gen u_dut (.*);

  task automatic chk(string tag, logic [PH_W-1:0] act, logic [PH_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: phase_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit ld, bit e, string tag);
    logic [ACC_W-1:0] n_acc;
    logic [VEL_W-1:0] n_vel;
    logic [PH_W-1:0]  n_ph;
    load_i = ld; en_i = e;
    @(posedge clk_i);
    if (ld) begin
      m_acc = init_acc_i; m_vel = init_vel_i; m_ph = init_ph_i;
      m_jerk = jerk_i; m_cnt = 0;
      m_div = (div_i == 0) ? 1 : int'(div_i);
    end else if (e) begin
      n_ph  = m_ph + m_vel[VEL_W-1:VEL_W-PH_W];
      n_vel = m_vel + m_acc[ACC_W-1:ACC_W-VEL_W];
      n_acc = m_acc;
      m_cnt++;
      if (m_cnt == m_div) begin m_cnt = 0; n_acc = m_acc + m_jerk; end
      m_ph = n_ph; m_vel = n_vel; m_acc = n_acc;
    end
    @(negedge clk_i);
    chk(tag, phase_o, m_ph);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 1, tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", phase_o, '0);
    rst_ni = 1;
    cyc(0, 1, "R1 after reset");

    // same-rate chain
    div_i = 1; jerk_i = 48'h0000_0100_0000; init_acc_i = 48'h0000_0200_0000;
    init_vel_i = 40'h00_0000_1000; init_ph_i = 32'h1234_5678;
    cyc(1, 0, "R2 load");
    chk("R2 load value", phase_o, 32'h1234_5678);
    run(20, "R3 R4 R6 W=1");

    // slow top stage, W=5, jerk large enough to show each update quickly
    div_i = 5; jerk_i = 48'h0001_0000_0000; init_acc_i = '0;
    init_vel_i = '0; init_ph_i = '0;
    cyc(1, 1, "R2 load with en");
    run(4, "R5 before first update");
    chk("R5 no accel yet", phase_o, '0);
    run(30, "R5 W=5");

    // enable gaps inside a period
    for (int i = 0; i < 12; i++) cyc(0, (i % 3) != 1, "R7 R5 gaps");
    cyc(0, 0, "R7 hold");
    cyc(0, 0, "R7 hold");

    // inputs changed without load
    div_i = 2; jerk_i = 48'hFFFF_0000_0000; init_ph_i = 32'hDEAD_BEEF;
    init_vel_i = 40'hFF_FFFF_FFFF; init_acc_i = 48'h7;
    run(15, "R9 no load");

    // W=0 acts as 1
    div_i = 0; jerk_i = 48'h0000_0001_0000; init_acc_i = '0;
    init_vel_i = '0; init_ph_i = '0;
    cyc(1, 0, "R6 load W=0");
    run(12, "R6 W=0");

    // wrap
    div_i = 3; jerk_i = 48'hFFFF_FFFF_FFFF; init_acc_i = 48'hFFFF_FFFF_FF00;
    init_vel_i = 40'h00_0000_0100; init_ph_i = 32'hFFFF_FFFF;
    cyc(1, 0, "R8 load");
    cyc(0, 1, "R8 wrap");
    chk("R8 phase wraps to 0", phase_o, 32'h0000_0000);
    run(25, "R8 wrap run");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule